// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Alarm

This block keeps wall-clock time and a calendar from a slow 32.768 kHz enable strobe. Seconds, minutes, hours, day of month, month, two-digit year (years since 2000) and weekday are presented as BCD bytes through a field-select read port. The same field codes load the running time, the alarm time, a control byte and a signed 16-bit drift-trim value. Once per second the block can raise a one-cycle periodic pulse, and a one-cycle alarm pulse when the running time equals the alarm time.

A control byte turns counting on, arms the alarm, picks 12-hour or 24-hour presentation of hours, and picks how often the periodic pulse fires. The drift trim shortens one second out of every `COMP_EVERY_SEC` seconds by the programmed number of slow-clock cycles. A negative value lengthens that second instead. Hours are held internally in 24-hour form, and both reads and loads convert to and from the 12-hour form when that mode is selected.

A sequencer with four states drives the second boundary. HALT is left for RUN when counting is enabled. RUN returns to HALT when counting is disabled, and moves to ADV when the prescaler has seen a full second of strobes. ADV always moves to EVAL. EVAL moves to RUN, or to HALT if counting was switched off. The calendar steps in ADV. Pulses are judged in EVAL against the new time. Strobes on `slow_en` must be at least three clock cycles apart.

Top module: `cal_rtc`

Field codes (shared by `wr_sel` and `rd_sel`): 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 weekday, 7 control, 8 to 13 alarm seconds, minutes, hours, day, month, year, 14 trim high byte, 15 trim low byte. Control bits: bit 0 run, bit 1 alarm arm, bit 2 twelve-hour mode, bits 4:3 periodic interval.

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00, weekday 0x00. Control and both trim bytes read 0x00. The alarm reads 00:00:00, day 0x01, month 0x01, year 0x04.
- R2: A write to code 7 stores only bits 4:0, and reading code 7 returns them with bits 7:5 zero.
- R3: With control bit 0 clear the time does not change under `slow_en` strobes. With it set, the seconds advance by one after every `CYC_PER_SEC` strobes.
- R4: Values loaded in BCD to time and alarm fields read back unchanged. A month load of 0x00 is stored as 1.
- R5: With control bit 2 set, hour reads carry PM in bit 7 and a BCD hour of 1 to 12 in bits 5:0. Internal hour 0 reads 0x12, hour 12 reads 0x92 and hour 13 reads 0x81.
- R6: With control bit 2 set, hour loads map 12 AM to internal hour 0 and 12 PM to internal hour 12. The stored hour reads back in 24-hour BCD once bit 2 is cleared.
- R7: Seconds and minutes roll over after 59 and hours after 23. The day rolls over after the month's last day (30 for months 4, 6, 9 and 11, otherwise 31), and the weekday wraps from 6 to 0 when the day changes.
- R8: February has 29 days when the year is divisible by 4 and 28 otherwise. December 31 of year 99 rolls over to January 1 of year 00.
- R9: The periodic pulse follows control bits 4:3. Value 0 fires every second. Value 1 fires when seconds reach 0. Value 2 fires when minutes and seconds reach 0. Value 3 fires when hours, minutes and seconds reach 0.
- R10: With control bit 1 set, the alarm pulse fires in the second in which seconds through year all equal the alarm fields. With bit 1 clear it never fires.
- R11: Every `COMP_EVERY_SEC`-th second since reset lasts `CYC_PER_SEC` minus the signed trim value in strobes. All other seconds last `CYC_PER_SEC` strobes.
- R12: If the trimmed second length would fall below 1 strobe, it is 1 strobe.
- R13: The periodic and alarm pulses are each one clock cycle wide, at most once per second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_en | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| wr_en | input | 1 | Load strobe for the field chosen by wr_sel |
| wr_sel | input | 4 | Field code for loads |
| wr_data | input | 8 | BCD or raw byte to load |
| rd_sel | input | 4 | Field code for reads |
| rd_data | output | 8 | BCD or raw byte of the chosen field |
| tick_o | output | 1 | Periodic one-cycle pulse |
| alarm_o | output | 1 | Alarm one-cycle pulse |

## Verification
The bench goes after the calendar edges: February 28 and 29 in leap and plain years, April 30, and the turn of year 99. A design with a wrong month table or leap test would land on a wrong day or month there. It drives the 12-hour boundaries (midnight, noon, 1 PM) in both directions, where an off-by-one mapping would shift the hour by twelve or show 00 instead of 12. It counts strobes exactly across the trimmed second with positive, negative and saturating trim, so a trim applied to the wrong second or with the wrong sign moves the second boundary by a visible number of strobes. For each periodic interval it runs cases that roll over and cases that do not, where a design that tested one field too few would fire an extra pulse.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_ADV  = 2'd2,
        ST_EVAL = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [6:0] yr;
        logic [3:0] mo;
        logic [4:0] dy;
        logic [4:0] hr;
        logic [5:0] mi;
        logic [5:0] se;
    } cal_t;

    localparam logic [3:0] SEL_CTRL   = 4'd7;
    localparam logic [3:0] SEL_TRIM_H = 4'd14;
    localparam logic [3:0] SEL_TRIM_L = 4'd15;

    function automatic logic [7:0] bin2bcd(input logic [6:0] v);
        return {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    function automatic logic [6:0] bcd2bin(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] mo, input logic [6:0] yr);
        logic [4:0] n;
        case (mo)
            4'd2:                      n = (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   n = 5'd30;
            default:                   n = 5'd31;
        endcase
        return n;
    endfunction

    function automatic logic [7:0] hour_rd(input logic [4:0] hr, input logic twelve);
        logic [4:0] h12;
        logic [7:0] b;
        if (!twelve)
            return bin2bcd({2'b00, hr});
        if (hr == 5'd0)       h12 = 5'd12;
        else if (hr > 5'd12)  h12 = hr - 5'd12;
        else                  h12 = hr;
        b = bin2bcd({2'b00, h12});
        return {(hr >= 5'd12), 1'b0, b[5:0]};
    endfunction

    function automatic logic [4:0] hour_wr(input logic [7:0] v, input logic twelve);
        logic [6:0] h;
        h = bcd2bin({2'b00, v[5:0]});
        if (!twelve)
            return h[4:0];
        if (h >= 7'd12)
            h = 7'd0;
        return h[4:0] + (v[7] ? 5'd12 : 5'd0);
    endfunction

endpackage

// File: rtl/rtc_seq_fsm.sv
module rtc_seq_fsm
    import cal_rtc_pkg::*;
#(
    parameter int CYC_PER_SEC    = 32768,
    parameter int COMP_EVERY_SEC = 3600
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_en,
    input  logic        slow_en,
    input  logic [15:0] trim,
    output logic        adv_o,
    output logic        eval_o
);
    localparam int CNT_W = $clog2(CYC_PER_SEC + 32768 + 1);
    localparam int IDX_W = $clog2(COMP_EVERY_SEC + 1);
    localparam logic signed [CNT_W+1:0] BASE_S = CYC_PER_SEC;
    localparam logic signed [CNT_W+1:0] ONE_S  = 1;

    seq_state_e st_q, st_d;
    logic [CNT_W-1:0] cnt_q, len;
    logic [IDX_W-1:0] idx_q;
    logic signed [CNT_W+1:0] trim_ext, trim_sel, len_raw;
    logic comp_due, wrap;

    always_comb begin
        comp_due = (idx_q == IDX_W'(COMP_EVERY_SEC - 1));
        trim_ext = {{(CNT_W + 2 - 16){trim[15]}}, trim};
        trim_sel = comp_due ? trim_ext : {(CNT_W + 2){1'b0}};
        len_raw  = BASE_S - trim_sel;
        len      = (len_raw < ONE_S) ? CNT_W'(1) : len_raw[CNT_W-1:0];
        wrap     = slow_en && (cnt_q >= len - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_HALT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT: if (run_en) st_d = ST_RUN;
            ST_RUN:  if (!run_en) st_d = ST_HALT;
                     else if (wrap) st_d = ST_ADV;
            ST_ADV:  st_d = ST_EVAL;
            ST_EVAL: st_d = run_en ? ST_RUN : ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (st_q == ST_RUN && run_en && slow_en) begin
            if (wrap) begin
                cnt_q <= '0;
                idx_q <= comp_due ? '0 : idx_q + IDX_W'(1);
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    always_comb begin
        adv_o  = (st_q == ST_ADV);
        eval_o = (st_q == ST_EVAL);
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import cal_rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       ld_en,
    input  logic [2:0] ld_sel,
    input  logic [6:0] ld_val,
    output cal_t       cal_q,
    output logic [2:0] wday_q
);
    cal_t       nx;
    logic [2:0] wd_nx;

    always_comb begin
        nx    = cal_q;
        wd_nx = wday_q;
        if (adv) begin
            if (cal_q.se >= 6'd59) begin
                nx.se = '0;
                if (cal_q.mi >= 6'd59) begin
                    nx.mi = '0;
                    if (cal_q.hr >= 5'd23) begin
                        nx.hr = '0;
                        wd_nx = (wday_q >= 3'd6) ? 3'd0 : wday_q + 3'd1;
                        if (cal_q.dy >= month_len(cal_q.mo, cal_q.yr)) begin
                            nx.dy = 5'd1;
                            if (cal_q.mo >= 4'd12) begin
                                nx.mo = 4'd1;
                                nx.yr = (cal_q.yr >= 7'd99) ? 7'd0 : cal_q.yr + 7'd1;
                            end else begin
                                nx.mo = cal_q.mo + 4'd1;
                            end
                        end else begin
                            nx.dy = cal_q.dy + 5'd1;
                        end
                    end else begin
                        nx.hr = cal_q.hr + 5'd1;
                    end
                end else begin
                    nx.mi = cal_q.mi + 6'd1;
                end
            end else begin
                nx.se = cal_q.se + 6'd1;
            end
        end
        if (ld_en) begin
            case (ld_sel)
                3'd0:    nx.se = ld_val[5:0];
                3'd1:    nx.mi = ld_val[5:0];
                3'd2:    nx.hr = ld_val[4:0];
                3'd3:    nx.dy = ld_val[4:0];
                3'd4:    nx.mo = ld_val[3:0];
                3'd5:    nx.yr = ld_val;
                default: wd_nx = ld_val[2:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_q  <= '{yr: 7'd0, mo: 4'd1, dy: 5'd1, hr: 5'd0, mi: 6'd0, se: 6'd0};
            wday_q <= 3'd0;
        end else begin
            cal_q  <= nx;
            wday_q <= wd_nx;
        end
    end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import cal_rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_en,
    input  logic [2:0] ld_sel,
    input  logic [6:0] ld_val,
    input  cal_t       now,
    output cal_t       alm_q,
    output logic       match_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_q <= '{yr: 7'd4, mo: 4'd1, dy: 5'd1, hr: 5'd0, mi: 6'd0, se: 6'd0};
        end else if (ld_en) begin
            case (ld_sel)
                3'd0:    alm_q.se <= ld_val[5:0];
                3'd1:    alm_q.mi <= ld_val[5:0];
                3'd2:    alm_q.hr <= ld_val[4:0];
                3'd3:    alm_q.dy <= ld_val[4:0];
                3'd4:    alm_q.mo <= ld_val[3:0];
                default: alm_q.yr <= ld_val;
            endcase
        end
    end

    assign match_o = (alm_q == now);
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
    import cal_rtc_pkg::*;
#(
    parameter int CYC_PER_SEC    = 32768,
    parameter int COMP_EVERY_SEC = 3600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_en,
    input  logic       wr_en,
    input  logic [3:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic [3:0] rd_sel,
    output logic [7:0] rd_data,
    output logic       tick_o,
    output logic       alarm_o
);
    logic [4:0]  ctrl_q;
    logic [15:0] trim_q;
    logic        adv_w, eval_w, alm_match;
    logic [6:0]  wr_val, mo_val;
    logic        ld_time, ld_alm, tick_cond;
    cal_t        cal_q, alm_q;
    logic [2:0]  wday_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            trim_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_CTRL)   ctrl_q       <= wr_data[4:0];
            if (wr_sel == SEL_TRIM_H) trim_q[15:8] <= wr_data;
            if (wr_sel == SEL_TRIM_L) trim_q[7:0]  <= wr_data;
        end
    end

    always_comb begin
        mo_val = bcd2bin(wr_data);
        case (wr_sel[2:0])
            3'd0, 3'd1: wr_val = bcd2bin({1'b0, wr_data[6:0]});
            3'd2:       wr_val = {2'b00, hour_wr(wr_data, ctrl_q[2])};
            3'd4:       wr_val = (mo_val == 7'd0) ? 7'd1 : mo_val;
            default:    wr_val = bcd2bin(wr_data);
        endcase
        ld_time = wr_en && (wr_sel < SEL_CTRL);
        ld_alm  = wr_en && wr_sel[3] && (wr_sel[2:0] < 3'd6);
    end

    rtc_seq_fsm #(
        .CYC_PER_SEC   (CYC_PER_SEC),
        .COMP_EVERY_SEC(COMP_EVERY_SEC)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (ctrl_q[0]),
        .slow_en(slow_en),
        .trim   (trim_q),
        .adv_o  (adv_w),
        .eval_o (eval_w)
    );

    rtc_calendar u_cal (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv_w),
        .ld_en (ld_time),
        .ld_sel(wr_sel[2:0]),
        .ld_val(wr_val),
        .cal_q (cal_q),
        .wday_q(wday_q)
    );

    rtc_alarm u_alm (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (ld_alm),
        .ld_sel (wr_sel[2:0]),
        .ld_val (wr_val),
        .now    (cal_q),
        .alm_q  (alm_q),
        .match_o(alm_match)
    );

    always_comb begin
        unique case (ctrl_q[4:3])
            2'd0: tick_cond = 1'b1;
            2'd1: tick_cond = (cal_q.se == 6'd0);
            2'd2: tick_cond = (cal_q.se == 6'd0) && (cal_q.mi == 6'd0);
            2'd3: tick_cond = (cal_q.se == 6'd0) && (cal_q.mi == 6'd0) && (cal_q.hr == 5'd0);
        endcase
        tick_o  = eval_w && tick_cond;
        alarm_o = eval_w && ctrl_q[1] && alm_match;
    end

    always_comb begin
        case (rd_sel)
            4'd0:    rd_data = bin2bcd({1'b0, cal_q.se});
            4'd1:    rd_data = bin2bcd({1'b0, cal_q.mi});
            4'd2:    rd_data = hour_rd(cal_q.hr, ctrl_q[2]);
            4'd3:    rd_data = bin2bcd({2'b00, cal_q.dy});
            4'd4:    rd_data = bin2bcd({3'b000, cal_q.mo});
            4'd5:    rd_data = bin2bcd(cal_q.yr);
            4'd6:    rd_data = {5'b0, wday_q};
            4'd7:    rd_data = {3'b000, ctrl_q};
            4'd8:    rd_data = bin2bcd({1'b0, alm_q.se});
            4'd9:    rd_data = bin2bcd({1'b0, alm_q.mi});
            4'd10:   rd_data = hour_rd(alm_q.hr, ctrl_q[2]);
            4'd11:   rd_data = bin2bcd({2'b00, alm_q.dy});
            4'd12:   rd_data = bin2bcd({3'b000, alm_q.mo});
            4'd13:   rd_data = bin2bcd(alm_q.yr);
            4'd14:   rd_data = trim_q[15:8];
            default: rd_data = trim_q[7:0];
        endcase
    end
endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk
    import cal_rtc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick_o,
    input logic       alarm_o,
    input logic       adv_w,
    input logic       eval_w,
    input logic       alm_match,
    input logic       wr_en,
    input logic [3:0] wr_sel,
    input logic [7:0] wr_data,
    input logic [4:0] ctrl_q,
    input cal_t       cal_q
);
    // R13: periodic pulse lasts one cycle
    a_r13_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R13: alarm pulse lasts one cycle
    a_r13_alarm_single: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |=> !alarm_o);

    // R10: alarm only when armed and times agree
    a_r10_alarm_match: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |-> (alm_match && ctrl_q[1]));

    // R2: control keeps the low five bits of the write
    a_r2_ctrl_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL) |=> (ctrl_q == $past(wr_data[4:0])));

    // R3: time holds without a second step or a load
    a_r3_time_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_w && !(wr_en && wr_sel < SEL_CTRL)) |=> $stable(cal_q));

    // R9: pulses are judged the cycle after the calendar step
    a_r9_eval_after_adv: assert property (@(posedge clk) disable iff (!rst_n)
        adv_w |=> eval_w);
endmodule

bind cal_rtc cal_rtc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_o   (tick_o),
    .alarm_o  (alarm_o),
    .adv_w    (adv_w),
    .eval_w   (eval_w),
    .alm_match(alm_match),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .ctrl_q   (ctrl_q),
    .cal_q    (cal_q)
);

// File: tb/cal_rtc_tb_top.sv
module cal_rtc_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CPS        = 16;
    localparam int EVERY      = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic       tick_o, alarm_o;

    int n_chk = 0;
    int n_fail = 0;
    int n_tick = 0;
    int n_alm = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cal_rtc #(.CYC_PER_SEC(CPS), .COMP_EVERY_SEC(EVERY)) dut_i (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .tick_o(tick_o), .alarm_o(alarm_o)
    );

    always @(negedge clk) begin
        if (rst_n && tick_o)  n_tick++;
        if (rst_n && alarm_o) n_alm++;
    end

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [7:0] to12(input int h);
        int h12;
        logic [7:0] b;
        h12 = (h % 12 == 0) ? 12 : h % 12;
        b = to_bcd(h12);
        return {(h >= 12), 1'b0, b[5:0]};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check_n(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] sel, output logic [7:0] d);
        @(negedge clk);
        rd_sel = sel;
        #1 d = rd_data;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            slow_en = 1'b1;
            @(negedge clk);
            slow_en = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic set_time(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] dy,
                            input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
        wr(4'd5, y); wr(4'd4, mo); wr(4'd3, dy);
        wr(4'd2, h); wr(4'd1, mi); wr(4'd0, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int t0, a0;
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset values
        rd(4'd0, v); check("R1 sec", v, 8'h00);
        rd(4'd1, v); check("R1 min", v, 8'h00);
        rd(4'd2, v); check("R1 hour", v, 8'h00);
        rd(4'd3, v); check("R1 day", v, 8'h01);
        rd(4'd4, v); check("R1 month", v, 8'h01);
        rd(4'd5, v); check("R1 year", v, 8'h00);
        rd(4'd6, v); check("R1 wday", v, 8'h00);
        rd(4'd7, v); check("R1 ctrl", v, 8'h00);
        rd(4'd14, v); check("R1 trim hi", v, 8'h00);
        rd(4'd15, v); check("R1 trim lo", v, 8'h00);
        rd(4'd8, v); check("R1 alarm sec", v, 8'h00);
        rd(4'd10, v); check("R1 alarm hour", v, 8'h00);
        rd(4'd11, v); check("R1 alarm day", v, 8'h01);
        rd(4'd12, v); check("R1 alarm month", v, 8'h01);
        rd(4'd13, v); check("R1 alarm year", v, 8'h04);

        // R2 control masking, random bytes
        for (int i = 0; i < 8; i++) begin
            logic [7:0] c;
            c = 8'($urandom) & 8'hFA;
            wr(4'd7, c);
            rd(4'd7, v); check("R2 ctrl mask", v, c & 8'h1F);
        end
        wr(4'd7, 8'h00);

        // R4 random load and read back in 24-hour mode
        for (int i = 0; i < 24; i++) begin
            int f, val, lim;
            logic [3:0] sel;
            f = int'($urandom_range(0, 11));
            case (f % 6)
                0, 1:    lim = 59;
                2:       lim = 23;
                3:       lim = 28;
                4:       lim = 12;
                default: lim = 99;
            endcase
            val = int'($urandom_range(0, lim));
            if ((f % 6) == 3 || (f % 6) == 4) val = (val == 0) ? 1 : val;
            sel = (f >= 6) ? 4'(8 + f - 6) : 4'(f);
            wr(sel, to_bcd(val));
            rd(sel, v); check("R4 load readback", v, to_bcd(val));
        end
        wr(4'd4, 8'h00);
        rd(4'd4, v); check("R4 month zero", v, 8'h01);

        // R5 and R6 random 12-hour round trips
        for (int i = 0; i < 12; i++) begin
            int h;
            h = int'($urandom_range(0, 23));
            wr(4'd7, 8'h04);
            wr(4'd2, to12(h));
            rd(4'd2, v); check("R5 12h read", v, to12(h));
            wr(4'd7, 8'h00);
            rd(4'd2, v); check("R6 12h load to 24h", v, to_bcd(h));
        end
        wr(4'd2, 8'h00); wr(4'd7, 8'h04);
        rd(4'd2, v); check("R5 midnight", v, 8'h12);
        wr(4'd7, 8'h00); wr(4'd2, 8'h12); wr(4'd7, 8'h04);
        rd(4'd2, v); check("R5 noon", v, 8'h92);
        wr(4'd7, 8'h00); wr(4'd2, 8'h13); wr(4'd7, 8'h04);
        rd(4'd2, v); check("R5 one pm", v, 8'h81);
        wr(4'd2, 8'h12); wr(4'd7, 8'h00);
        rd(4'd2, v); check("R6 12 AM", v, 8'h00);
        wr(4'd7, 8'h04); wr(4'd2, 8'h92); wr(4'd7, 8'h00);
        rd(4'd2, v); check("R6 12 PM", v, 8'h12);

        // R3 counting and halt
        do_reset();
        pulses(20);
        rd(4'd0, v); check("R3 halted", v, 8'h00);
        wr(4'd7, 8'h01);
        t0 = n_tick;
        pulses(CPS - 1);
        rd(4'd0, v); check("R3 one short", v, 8'h00);
        pulses(1);
        rd(4'd0, v); check("R3 first second", v, 8'h01);
        pulses(2 * CPS);
        rd(4'd0, v); check("R3 three seconds", v, 8'h03);
        check_n("R13 R9 one tick per second", n_tick - t0, 3);
        wr(4'd7, 8'h00);
        pulses(CPS);
        rd(4'd0, v); check("R3 disabled hold", v, 8'h03);

        // R7 R8 calendar rollovers
        do_reset();
        wr(4'd7, 8'h01);
        set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        wr(4'd6, 8'h06);
        pulses(CPS);
        rd(4'd3, v); check("R8 leap feb 29", v, 8'h29);
        rd(4'd4, v); check("R8 leap month", v, 8'h02);
        rd(4'd6, v); check("R7 wday wrap", v, 8'h00);
        rd(4'd2, v); check("R7 hour wrap", v, 8'h00);
        set_time(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
        pulses(CPS);
        rd(4'd4, v); check("R8 leap to march", v, 8'h03);
        rd(4'd3, v); check("R8 leap to day 1", v, 8'h01);
        set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        pulses(CPS);
        rd(4'd4, v); check("R8 plain feb end", v, 8'h03);
        set_time(8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
        pulses(CPS);
        rd(4'd4, v); check("R7 april end month", v, 8'h05);
        rd(4'd3, v); check("R7 april end day", v, 8'h01);
        set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
        pulses(CPS);
        rd(4'd5, v); check("R8 year wrap", v, 8'h00);
        rd(4'd4, v); check("R8 year wrap month", v, 8'h01);
        rd(4'd1, v); check("R7 minute wrap", v, 8'h00);

        // R9 periodic intervals
        do_reset();
        wr(4'd0, 8'h58); wr(4'd7, 8'h09);
        t0 = n_tick; pulses(3 * CPS);
        check_n("R9 mode1 seconds zero", n_tick - t0, 1);
        wr(4'd7, 8'h11);
        wr(4'd1, 8'h59); wr(4'd0, 8'h58);
        t0 = n_tick; pulses(3 * CPS);
        check_n("R9 mode2 minute rollover", n_tick - t0, 1);
        wr(4'd1, 8'h10); wr(4'd0, 8'h58);
        t0 = n_tick; pulses(3 * CPS);
        check_n("R9 mode2 no rollover", n_tick - t0, 0);
        wr(4'd7, 8'h19);
        wr(4'd2, 8'h23); wr(4'd1, 8'h59); wr(4'd0, 8'h58);
        t0 = n_tick; pulses(3 * CPS);
        check_n("R9 mode3 day rollover", n_tick - t0, 1);
        wr(4'd2, 8'h05); wr(4'd1, 8'h59); wr(4'd0, 8'h58);
        t0 = n_tick; pulses(3 * CPS);
        check_n("R9 mode3 hour only", n_tick - t0, 0);

        // R10 alarm
        do_reset();
        wr(4'd13, 8'h00); wr(4'd8, 8'h02);
        wr(4'd7, 8'h03);
        a0 = n_alm; pulses(3 * CPS);
        check_n("R10 alarm fires once", n_alm - a0, 1);
        wr(4'd7, 8'h01); wr(4'd0, 8'h00);
        a0 = n_alm; pulses(3 * CPS);
        check_n("R10 alarm disarmed", n_alm - a0, 0);

        // R11 positive trim shortens the fifth second
        do_reset();
        wr(4'd14, 8'h00); wr(4'd15, 8'h03);
        rd(4'd15, v); check("R11 trim lo readback", v, 8'h03);
        wr(4'd7, 8'h01);
        pulses((EVERY - 1) * CPS);
        rd(4'd0, v); check("R11 before trimmed second", v, 8'h04);
        pulses(CPS - 4);
        rd(4'd0, v); check("R11 trimmed one short", v, 8'h04);
        pulses(1);
        rd(4'd0, v); check("R11 trimmed second ends", v, 8'h05);
        pulses(CPS);
        rd(4'd0, v); check("R11 next second normal", v, 8'h06);

        // R11 negative trim lengthens it
        do_reset();
        wr(4'd14, 8'hFF); wr(4'd15, 8'hFC);
        rd(4'd14, v); check("R11 trim hi readback", v, 8'hFF);
        wr(4'd7, 8'h01);
        pulses((EVERY - 1) * CPS + CPS + 3);
        rd(4'd0, v); check("R11 lengthened one short", v, 8'h04);
        pulses(1);
        rd(4'd0, v); check("R11 lengthened ends", v, 8'h05);

        // R12 saturation
        do_reset();
        wr(4'd14, 8'h00); wr(4'd15, 8'h64);
        wr(4'd7, 8'h01);
        pulses((EVERY - 1) * CPS);
        rd(4'd0, v); check("R12 before saturated", v, 8'h04);
        pulses(1);
        rd(4'd0, v); check("R12 one strobe second", v, 8'h05);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule